// File: doc/BRIEF.md
# Fault Status Supervisor with Watchdog

This block gathers fault conditions for a multi-channel playback engine and presents them to a host controller. Six fault sources are tracked: an internal watchdog whose counter the host must restart periodically, and five conditions that arrive as digital inputs from sensing logic elsewhere: reset-counter overflow, over-temperature, speaker short, speaker disconnect and flash error. Each source has its own enable in a safety-configuration register. A detected fault is latched in a sticky error bit. It can be cleared only by an explicit clear strobe, and only once its condition has gone away.

The watchdog counts pulses of a timebase tick input rather than raw clocks, so one parameter scales the timeout for simulation. Four timeouts are selectable. Two status pins each show one of three things, chosen per pin: a channel's busy flag, a channel's ready flag, or the error summary.

Top module: `fault_supervisor`

## Requirements
- R1: After reset all error bits read 0, `err_any` is 0, all enables are 0, and both status pins show the busy flag (`ch_busy_n`) of channel 0.
- R2: While the watchdog enable (`safe_en[0]`) is 1, the counter advances on each `tick` pulse. The watchdog error bit `err_bits[0]` is set on the tick that completes the selected timeout of 1, 4, 16 or 32 units (codes 0, 1, 2 and 3 on `tsel`; one unit is TICKS_PER_UNIT ticks). The counter then starts again from zero. While the enable is 0, the counter is held at zero.
- R3: A `wdt_clr` strobe restarts the count, so a full timeout of ticks must follow it before the watchdog bit is set.
- R4: With its enable set, a high fault input sets its error bit at the next clock edge. The mapping is `flt_in[0]` to bit 1 (reset-counter overflow), `flt_in[1]` to bit 2 (over-temperature), `flt_in[2]` to bit 3 (speaker short), `flt_in[3]` to bit 4 (speaker open) and `flt_in[4]` to bit 5 (flash). With its enable at 0 the input sets nothing.
- R5: Error bits stay set after their condition goes away, until a clear strobe.
- R6: An `err_clr` strobe clears every error bit whose condition is inactive in that cycle. A bit whose condition is still active stays set.
- R7: `err_any` is 1 exactly when some latched error bit also has its enable set. Disabling a source hides its bit from the summary but does not erase the bit.
- R8: A status pin with code 0 shows `ch_busy_n` of its selected channel, code 1 shows `ch_ready` of that channel, code 2 shows the inverted error summary (low means an error is present), and code 3 drives the pin high.
- R9: After reset the timeout code is 2 (16 units).
- R10: Writing a new timeout code restarts the watchdog count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse, one cycle wide |
| safe_wr | input | 1 | Write strobe for the enable register |
| safe_en | input | 6 | Enables: bit 0 watchdog, bits 1 to 5 external faults |
| tsel_wr | input | 1 | Write strobe for the timeout code |
| tsel | input | 2 | Timeout code |
| wdt_clr | input | 1 | Watchdog restart strobe |
| err_clr | input | 1 | Error clear strobe |
| flt_in | input | 5 | External fault conditions |
| outsel_wr | input | 1 | Write strobe for a status pin selection |
| outsel_pin | input | 1 | Which status pin is written |
| outsel_code | input | 2 | Source code for that pin |
| outsel_ch | input | 2 | Channel shown by that pin |
| ch_busy_n | input | 4 | Per-channel busy flags, active low |
| ch_ready | input | 4 | Per-channel ready flags |
| err_bits | output | 6 | Latched error bits |
| err_any | output | 1 | Enabled error summary |
| stat_pin | output | 2 | Status pins |

## Verification
The assertions assume that `flt_in` and all strobes are synchronous to `clk` and settled at each rising edge. They also assume that `tick` is high for no more than one cycle per timebase period, so each counter step corresponds to exactly one tick. The bench changes every input only just after a falling edge and raises `tick` for single cycles. With the tick unit scaled down to two ticks, every timeout code can be swept in full, as can every fault source, every pin code and every channel.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int NUM_FLT   = 6;
  localparam int FB_WDT    = 0;
  localparam int NUM_EXT   = NUM_FLT - 1;

  typedef enum logic [1:0] {
    PIN_BUSY = 2'b00,
    PIN_RDY  = 2'b01,
    PIN_ERR  = 2'b10,
    PIN_IDLE = 2'b11
  } pin_code_e;

  localparam logic [1:0] TSEL_DEFAULT = 2'b10;
endpackage

// File: rtl/fs_rst_sync.sv
module fs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/fs_wdt.sv
module fs_wdt #(
  parameter int UNIT  = 125,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic [1:0]       tsel,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] lim,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    unique case (tsel)
      2'd0:    lim = CNT_W'(UNIT);
      2'd1:    lim = CNT_W'(4 * UNIT);
      2'd2:    lim = CNT_W'(16 * UNIT);
      default: lim = CNT_W'(32 * UNIT);
    endcase
  end

  assign ovf = run && tick && !restart && (cnt == lim - CNT_W'(1));

  always_comb begin
    cnt_d = cnt;
    if (restart || !run)  cnt_d = '0;
    else if (ovf)         cnt_d = '0;
    else if (tick)        cnt_d = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/fs_flag.sv
module fs_flag #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] hold_v,
  input  logic         clr,
  output logic [N-1:0] q
);
  logic [N-1:0] q_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      q_d[i] = q[i];
      if (clr && !hold_v[i]) q_d[i] = 1'b0;
      if (set_v[i])          q_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= q_d[i];
    end
  end
endmodule

// File: rtl/fs_pinmux.sv
module fs_pinmux #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic [1:0]     code,
  input  logic [CHW-1:0] ch,
  input  logic [NCH-1:0] busy_n,
  input  logic [NCH-1:0] ready,
  input  logic           err_any,
  output logic           pin
);
  import fs_pkg::*;

  always_comb begin
    unique case (pin_code_e'(code))
      PIN_BUSY: pin = busy_n[ch];
      PIN_RDY:  pin = ready[ch];
      PIN_ERR:  pin = !err_any;
      default:  pin = 1'b1;
    endcase
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int TICKS_PER_UNIT = 125,
  parameter int NCH            = 4,
  parameter int NPIN           = 2,
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int PINW  = (NPIN > 1) ? $clog2(NPIN) : 1,
  localparam int NFLT  = fs_pkg::NUM_FLT,
  localparam int NEXT  = fs_pkg::NUM_EXT,
  localparam int CNT_W = $clog2(32 * TICKS_PER_UNIT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            safe_wr,
  input  logic [NFLT-1:0] safe_en,
  input  logic            tsel_wr,
  input  logic [1:0]      tsel,
  input  logic            wdt_clr,
  input  logic            err_clr,
  input  logic [NEXT-1:0] flt_in,
  input  logic            outsel_wr,
  input  logic [PINW-1:0] outsel_pin,
  input  logic [1:0]      outsel_code,
  input  logic [CHW-1:0]  outsel_ch,
  input  logic [NCH-1:0]  ch_busy_n,
  input  logic [NCH-1:0]  ch_ready,
  output logic [NFLT-1:0] err_bits,
  output logic            err_any,
  output logic [NPIN-1:0] stat_pin
);
  import fs_pkg::*;

  logic            rst_i_n;
  logic [NFLT-1:0] en_q, en_d;
  logic [1:0]      tsel_q, tsel_d;
  logic [1:0]      pcode_q [NPIN];
  logic [1:0]      pcode_d [NPIN];
  logic [CHW-1:0]  pch_q   [NPIN];
  logic [CHW-1:0]  pch_d   [NPIN];

  logic [CNT_W-1:0] wdt_cnt, wdt_lim;
  logic             wdt_ovf, wdt_restart;
  logic [NFLT-1:0]  cond_raw, cond_set;

  fs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  // configuration next state
  always_comb begin
    en_d   = en_q;
    tsel_d = tsel_q;
    if (safe_wr) en_d   = safe_en;
    if (tsel_wr) tsel_d = tsel;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      en_q   <= '0;
      tsel_q <= TSEL_DEFAULT;
    end else begin
      en_q   <= en_d;
      tsel_q <= tsel_d;
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    always_comb begin
      pcode_d[p] = pcode_q[p];
      pch_d[p]   = pch_q[p];
      if (outsel_wr && (outsel_pin == PINW'(p))) begin
        pcode_d[p] = outsel_code;
        pch_d[p]   = outsel_ch;
      end
    end

    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) begin
        pcode_q[p] <= PIN_BUSY;
        pch_q[p]   <= '0;
      end else begin
        pcode_q[p] <= pcode_d[p];
        pch_q[p]   <= pch_d[p];
      end
    end

    fs_pinmux #(.NCH(NCH), .CHW(CHW)) u_mux (
      .code    (pcode_q[p]),
      .ch      (pch_q[p]),
      .busy_n  (ch_busy_n),
      .ready   (ch_ready),
      .err_any (err_any),
      .pin     (stat_pin[p])
    );
  end

  assign wdt_restart = wdt_clr || tsel_wr;

  fs_wdt #(.UNIT(TICKS_PER_UNIT), .CNT_W(CNT_W)) u_wdt (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .tick    (tick),
    .run     (en_q[FB_WDT]),
    .restart (wdt_restart),
    .tsel    (tsel_q),
    .cnt     (wdt_cnt),
    .lim     (wdt_lim),
    .ovf     (wdt_ovf)
  );

  assign cond_raw = {flt_in, wdt_ovf};
  assign cond_set = cond_raw & en_q;

  fs_flag #(.N(NFLT)) u_flag (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .set_v  (cond_set),
    .hold_v (cond_raw),
    .clr    (err_clr),
    .q      (err_bits)
  );

  assign err_any = |(err_bits & en_q);
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk #(
  parameter int NFLT  = 6,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             err_clr,
  input logic             wdt_restart,
  input logic             wdt_run,
  input logic [CNT_W-1:0] wdt_cnt,
  input logic [CNT_W-1:0] wdt_lim,
  input logic [NFLT-1:0]  cond_raw,
  input logic [NFLT-1:0]  en_q,
  input logic [NFLT-1:0]  err_bits,
  input logic             err_any
);
  assert_cnt_below_lim_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_cnt < wdt_lim);

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_run |=> (wdt_cnt == '0));

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_run && !tick && !wdt_restart) |=> $stable(wdt_cnt));

  assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_restart |=> (wdt_cnt == '0));

  assert_enabled_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cond_raw & en_q)) |=> ((err_bits & $past(cond_raw & en_q)) == $past(cond_raw & en_q)));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> ((err_bits & $past(err_bits)) == $past(err_bits)));

  assert_clear_inactive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> ((err_bits & ~$past(cond_raw)) == '0));

  assert_summary_needs_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |-> ((err_bits != '0) && (en_q != '0)));
endmodule

bind fault_supervisor fault_supervisor_chk #(.NFLT(NFLT), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .err_clr     (err_clr),
  .wdt_restart (wdt_restart),
  .wdt_run     (en_q[0]),
  .wdt_cnt     (wdt_cnt),
  .wdt_lim     (wdt_lim),
  .cond_raw    (cond_raw),
  .en_q        (en_q),
  .err_bits    (err_bits),
  .err_any     (err_any)
);

// File: tb/fault_supervisor_tb_top.sv
module fault_supervisor_tb_top;
  localparam int U = 2;

  logic       clk = 1'b0;
  logic       rst_n, tick, safe_wr, tsel_wr, wdt_clr, err_clr, outsel_wr;
  logic [5:0] safe_en;
  logic [1:0] tsel, outsel_code, outsel_ch;
  logic       outsel_pin;
  logic [4:0] flt_in;
  logic [3:0] ch_busy_n, ch_ready;
  logic [5:0] err_bits;
  logic       err_any;
  logic [1:0] stat_pin;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fault_supervisor #(.TICKS_PER_UNIT(U)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .safe_wr(safe_wr), .safe_en(safe_en),
    .tsel_wr(tsel_wr), .tsel(tsel), .wdt_clr(wdt_clr), .err_clr(err_clr),
    .flt_in(flt_in), .outsel_wr(outsel_wr), .outsel_pin(outsel_pin),
    .outsel_code(outsel_code), .outsel_ch(outsel_ch), .ch_busy_n(ch_busy_n),
    .ch_ready(ch_ready), .err_bits(err_bits), .err_any(err_any), .stat_pin(stat_pin)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      cyc();
    end
    tick = 1'b0;
  endtask

  task automatic wr_safe(logic [5:0] v);
    safe_en = v; safe_wr = 1'b1; cyc(); safe_wr = 1'b0;
  endtask

  task automatic wr_tsel(logic [1:0] v);
    tsel = v; tsel_wr = 1'b1; cyc(); tsel_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1; cyc(); err_clr = 1'b0;
  endtask

  task automatic wr_sel(logic p, logic [1:0] c, logic [1:0] ch);
    outsel_pin = p; outsel_code = c; outsel_ch = ch; outsel_wr = 1'b1; cyc(); outsel_wr = 1'b0;
  endtask

  function automatic int units(int c);
    return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 16 : 32;
  endfunction

  initial begin
    rst_n = 1'b0; tick = 0; safe_wr = 0; tsel_wr = 0; wdt_clr = 0; err_clr = 0;
    outsel_wr = 0; safe_en = '0; tsel = '0; outsel_code = '0; outsel_ch = '0;
    outsel_pin = 0; flt_in = '0; ch_busy_n = 4'b1111; ch_ready = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();

    // R1 reset state
    check("R1 err_bits", err_bits, 0);
    check("R1 err_any", err_any, 0);
    ch_busy_n = 4'b1110; cyc();
    check("R1 pins follow busy ch0", stat_pin, 2'b00);
    ch_busy_n = 4'b0001; cyc();
    check("R1 pins follow busy ch0", stat_pin, 2'b11);
    ch_busy_n = 4'b1111;

    // R9 default timeout is 16 units
    wr_safe(6'b000001);
    ticks(16 * U - 1);
    check("R9 no overflow before default timeout", err_bits[0], 0);
    ticks(1);
    check("R9 overflow at default timeout", err_bits[0], 1);
    check("R9 summary", err_any, 1);
    pulse_clr();
    check("R6 watchdog bit cleared", err_bits, 0);

    // R2 sweep over all timeout codes, two periods each
    for (int c = 0; c < 4; c++) begin
      wr_tsel(2'(c));
      for (int rep = 0; rep < 2; rep++) begin
        ticks(units(c) * U - 1);
        check("R2 before timeout", err_bits[0], 0);
        ticks(1);
        check("R2 at timeout", err_bits[0], 1);
        pulse_clr();
        check("R2 cleared", err_bits[0], 0);
      end
    end

    // R2 counter held while disabled (code 3 still selected)
    wr_safe(6'b000000);
    ticks(70);
    check("R2 disabled no overflow", err_bits[0], 0);
    wr_safe(6'b000001);
    ticks(32 * U - 1);
    check("R2 fresh count after enable", err_bits[0], 0);
    ticks(1);
    check("R2 overflow after enable", err_bits[0], 1);
    pulse_clr();

    // R3 restart strobe
    wr_tsel(2'd1);
    ticks(4 * U - 1);
    wdt_clr = 1'b1; cyc(); wdt_clr = 1'b0;
    ticks(4 * U - 1);
    check("R3 no overflow after restart", err_bits[0], 0);
    ticks(1);
    check("R3 overflow full period after restart", err_bits[0], 1);
    pulse_clr();

    // R10 timeout write restarts count
    ticks(5);
    wr_tsel(2'd1);
    ticks(4 * U - 1);
    check("R10 no overflow after timeout write", err_bits[0], 0);
    ticks(1);
    check("R10 overflow after timeout write", err_bits[0], 1);
    pulse_clr();
    wr_safe(6'b000000);

    // R4/R5/R6 per external fault
    for (int k = 0; k < 5; k++) begin
      logic [5:0] b;
      b = 6'(1) << (k + 1);
      wr_safe(b);
      flt_in = 5'(1) << k; cyc();
      check("R4 enabled fault latched", err_bits, b);
      check("R7 summary with enabled bit", err_any, 1);
      flt_in = '0; cyc();
      check("R5 sticky after fault gone", err_bits, b);
      pulse_clr();
      check("R6 clear inactive fault", err_bits, 0);
      flt_in = 5'(1) << k; cyc();
      pulse_clr();
      check("R6 active fault survives clear", err_bits, b);
      flt_in = '0; pulse_clr();
      check("R6 cleared after fault gone", err_bits, 0);
      wr_safe(6'b000000);
      flt_in = 5'(1) << k; cyc(); cyc();
      check("R4 disabled fault ignored", err_bits, 0);
      check("R4 disabled summary", err_any, 0);
      flt_in = '0; cyc();
    end

    // R7 summary masking
    wr_safe(6'b000110);
    flt_in = 5'b00011; cyc(); flt_in = '0;
    check("R7 two bits latched", err_bits, 6'b000110);
    wr_safe(6'b000100);
    check("R7 one enabled bit", err_any, 1);
    wr_safe(6'b000000);
    check("R7 no enabled bit", err_any, 0);
    check("R7 bits kept when disabled", err_bits, 6'b000110);
    wr_sel(1'b1, 2'b10, 2'd0);
    check("R8 summary pin idle high", stat_pin[1], 1);
    wr_safe(6'b000010);
    check("R8 summary pin low on error", stat_pin[1], 0);
    wr_safe(6'b000000);
    pulse_clr();
    check("R6 all cleared", err_bits, 0);

    // R8 pin mux sweep
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 4; c++)
        for (int ch = 0; ch < 4; ch++)
          for (int pat = 0; pat < 2; pat++) begin
            logic exp_pin;
            wr_sel(1'(p), 2'(c), 2'(ch));
            ch_busy_n = pat ? 4'b1001 : 4'b0110;
            ch_ready  = pat ? 4'b0011 : 4'b1100;
            cyc();
            case (c)
              0: exp_pin = ch_busy_n[ch];
              1: exp_pin = ch_ready[ch];
              default: exp_pin = 1'b1;
            endcase
            check("R8 pin source", stat_pin[p], exp_pin);
          end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule